// File: doc/BRIEF.md
# Load Queue with Store-Ordering Violation Detection

This block keeps the loads that are in flight in a processor core in program order, in a circular buffer. A small pointer tracker runs beside it for the companion store queue. When a load is allocated, the block hands back the slot it was given and a snapshot of the store-queue tail. When a store is allocated, the block hands back the current load-queue tail. The store keeps that index until it executes.

When a store's address is known, the store presents the address together with its recorded load index. All loads from that index up to the current load tail are compared with the store address in parallel, at a granularity of 256-byte regions. If any of them matches, a younger load has already read memory ahead of an older store. The oldest such load is latched as the violator, a counter advances, and the store is flagged as faulting in the same cycle. The violator stays latched until it is read out. While it is held, no further scans take effect.

Loads leave the queue in two ways. Commit retires them from the head up to a given sequence number. Squash discards them from the tail down to a given sequence number. A single blocked-load flag is released by a squash that reaches back past the blocked load. The block also reports the number of free entries, taken over both queues.

Top module: `load_order_queue`

## Requirements
- R1: The load queue has LQ_DEPTH+1 slots. It reports full when (tail+1) modulo the slot count equals the head, so at most LQ_DEPTH loads are held. An allocation request while full is ignored.
- R2: alloc_ld_idx shows the current load tail, which is the slot the next load receives. alloc_ld_sqtag shows {0, store tail}, or all ones when the store queue is empty. alloc_st_lqidx shows the current load tail.
- R3: A store execute compares only occupied load slots that lie from its load index, inclusive, up to the load tail, exclusive, following the circular order. The window is empty when the index equals the tail.
- R4: A load matches a store when the two addresses are equal after the low 8 bits are discarded (addr >> 8). The low 8 bits have no effect.
- R5: On a match, st_fault is high in the execute cycle. On the next cycle viol_valid is set, viol_idx and viol_seq hold the matching load closest to the start index, and viol_count is one higher.
- R6: While viol_valid is set, a store execute raises no fault and leaves the violator and the counter unchanged. A viol_rd pulse clears viol_valid on the next cycle.
- R7: A load whose address has not been written since it was allocated never matches.
- R8: A commit removes loads from the head, one after another, while the queue is non-empty and the head load's sequence number is at or below commit_seq.
- R9: A squash removes loads from the tail backwards while their sequence number is above squash_seq. When squash is present, load allocation and commit in the same cycle are ignored.
- R10: blk_set latches a blocked flag and the blocked load's sequence number. A squash whose squash_seq is below that number clears the flag. Any other squash leaves it set.
- R11: free_entries equals min(LQ_DEPTH − loads held, SQ_DEPTH − stores held).
- R12: The store tracker holds at most SQ_DEPTH stores. A st_alloc while full is ignored. st_free retires the oldest store and has no effect when the tracker is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_ld | input | 1 | Allocate a load at the tail |
| alloc_ld_seq | input | SEQ_W | Sequence number of the new load |
| alloc_ld_idx | output | IW | Slot the next load receives |
| alloc_ld_sqtag | output | SIW+1 | Store-tail snapshot for the new load, all ones if no stores |
| ld_addr_wr | input | 1 | Write a load's address |
| ld_addr_idx | input | IW | Slot whose address is written |
| ld_addr | input | ADDR_W | Load address |
| st_alloc | input | 1 | Allocate a store |
| st_free | input | 1 | Retire the oldest store |
| alloc_st_lqidx | output | IW | Load-tail snapshot for the new store |
| st_exec | input | 1 | Store address is known; run the ordering check |
| st_exec_addr | input | ADDR_W | Store address |
| st_exec_lqidx | input | IW | Load index recorded at store allocation |
| st_fault | output | 1 | Store found a younger matching load |
| viol_valid | output | 1 | A violator is latched |
| viol_idx | output | IW | Slot of the violating load |
| viol_seq | output | SEQ_W | Sequence number of the violating load |
| viol_rd | input | 1 | Read the violator and clear it |
| viol_count | output | CNT_W | Number of violations seen |
| commit_valid | input | 1 | Commit request |
| commit_seq | input | SEQ_W | Youngest sequence number allowed to retire |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Loads above this number are discarded |
| blk_set | input | 1 | Mark a load as blocked |
| blk_seq | input | SEQ_W | Sequence number of the blocked load |
| ld_blocked | output | 1 | Blocked-load flag |
| ld_count | output | IW | Loads held |
| ld_full | output | 1 | Load queue full |
| free_entries | output | FW | Free entries across both queues |

## Verification
The bench builds the block with LQ_DEPTH=3, SQ_DEPTH=2 and 12-bit addresses. With these values there are four load slots and three store slots, and both queues can be filled and made to wrap within a few cycles. With three loads in place, the bench runs every start index against every pattern of matching loads. Matching addresses differ only in their low byte, and non-matching addresses share the low byte but differ above bit 8, so both the window edges and the oldest-first choice are covered for every case. Separate sequences make the load ring wrap, leave committed slots with stale matching addresses, fill the store tracker and interleave squash with allocation.

// File: rtl/lq_pkg.sv
package lq_pkg;

    // Addresses are compared above this bit (256-byte regions)
    localparam int MATCH_LSB = 8;

    typedef enum logic {
        SWEEP_FROM_HEAD,
        SWEEP_FROM_TAIL
    } sweep_dir_e;

    // (a + b) mod n, for a < n and b <= n
    function automatic int unsigned ring_step(int unsigned a, int unsigned b, int unsigned n);
        int unsigned s;
        s = a + b;
        return (s >= n) ? s - n : s;
    endfunction

    // steps from 'from' forward to 'to' on a ring of n
    function automatic int unsigned ring_dist(int unsigned from, int unsigned to, int unsigned n);
        return (to >= from) ? to - from : to + n - from;
    endfunction

endpackage

// File: rtl/lq_sweep.sv
// Counts how many consecutive loads leave the queue, starting at the head
// (commit) or walking back from the tail (squash).
module lq_sweep
    import lq_pkg::*;
#(
    parameter int         SLOTS = 4,
    parameter int         IW    = 2,
    parameter int         SEQ_W = 8,
    parameter sweep_dir_e DIR   = SWEEP_FROM_HEAD
) (
    input  logic [SLOTS-1:0][SEQ_W-1:0] seqs,
    input  logic [IW-1:0]               origin,
    input  logic [IW-1:0]               cnt,
    input  logic [SEQ_W-1:0]            bound,
    output logic [IW-1:0]               take
);
    generate
        if (DIR == SWEEP_FROM_HEAD) begin : g_head
            always_comb begin
                logic run;
                run  = 1'b1;
                take = '0;
                for (int k = 0; k < SLOTS - 1; k++) begin
                    if (run && (IW'(k) < cnt) &&
                        (seqs[IW'(ring_step(32'(origin), k, SLOTS))] <= bound))
                        take = take + IW'(1);
                    else
                        run = 1'b0;
                end
            end
        end else begin : g_tail
            always_comb begin
                logic run;
                run  = 1'b1;
                take = '0;
                for (int k = 0; k < SLOTS - 1; k++) begin
                    if (run && (IW'(k) < cnt) &&
                        (seqs[IW'(ring_step(32'(origin), SLOTS - 1 - k, SLOTS))] > bound))
                        take = take + IW'(1);
                    else
                        run = 1'b0;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/lq_scan.sv
// Parallel coarse address compare plus an oldest-first pick inside the
// window [start, tail).
module lq_scan
    import lq_pkg::*;
#(
    parameter int SLOTS  = 4,
    parameter int IW     = 2,
    parameter int ADDR_W = 16
) (
    input  logic [SLOTS-1:0][ADDR_W-1:0] addrs,
    input  logic [SLOTS-1:0]             live,
    input  logic [IW-1:0]                start,
    input  logic [IW-1:0]                tail,
    input  logic [ADDR_W-1:0]            st_addr,
    output logic                         hit,
    output logic [IW-1:0]                pick
);
    logic [SLOTS-1:0] match;

    generate
        for (genvar i = 0; i < SLOTS; i++) begin : g_cmp
            assign match[i] = live[i] &&
                ((addrs[i] >> MATCH_LSB) == (st_addr >> MATCH_LSB));
        end
    endgenerate

    always_comb begin
        int unsigned span;
        int unsigned idx;
        span = ring_dist(32'(start), 32'(tail), SLOTS);
        hit  = 1'b0;
        pick = '0;
        for (int k = 0; k < SLOTS; k++) begin
            idx = ring_step(32'(start), k, SLOTS);
            if (!hit && (k < int'(span)) && match[IW'(idx)]) begin
                hit  = 1'b1;
                pick = IW'(idx);
            end
        end
    end
endmodule

// File: rtl/load_order_queue.sv
module load_order_queue
    import lq_pkg::*;
#(
    parameter int LQ_DEPTH = 8,
    parameter int SQ_DEPTH = 8,
    parameter int ADDR_W   = 32,
    parameter int SEQ_W    = 16,
    parameter int CNT_W    = 16,
    localparam int SLOTS   = LQ_DEPTH + 1,
    localparam int SSLOTS  = SQ_DEPTH + 1,
    localparam int IW      = $clog2(SLOTS),
    localparam int SIW     = $clog2(SSLOTS),
    localparam int FW      = (IW > SIW) ? IW : SIW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_ld,
    input  logic [SEQ_W-1:0]  alloc_ld_seq,
    output logic [IW-1:0]     alloc_ld_idx,
    output logic [SIW:0]      alloc_ld_sqtag,
    input  logic              ld_addr_wr,
    input  logic [IW-1:0]     ld_addr_idx,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              st_alloc,
    input  logic              st_free,
    output logic [IW-1:0]     alloc_st_lqidx,
    input  logic              st_exec,
    input  logic [ADDR_W-1:0] st_exec_addr,
    input  logic [IW-1:0]     st_exec_lqidx,
    output logic              st_fault,
    output logic              viol_valid,
    output logic [IW-1:0]     viol_idx,
    output logic [SEQ_W-1:0]  viol_seq,
    input  logic              viol_rd,
    output logic [CNT_W-1:0]  viol_count,
    input  logic              commit_valid,
    input  logic [SEQ_W-1:0]  commit_seq,
    input  logic              squash_valid,
    input  logic [SEQ_W-1:0]  squash_seq,
    input  logic              blk_set,
    input  logic [SEQ_W-1:0]  blk_seq,
    output logic              ld_blocked,
    output logic [IW-1:0]     ld_count,
    output logic              ld_full,
    output logic [FW-1:0]     free_entries
);
    // ---------------- load ring state ----------------
    logic [SLOTS-1:0][SEQ_W-1:0]  seqs;
    logic [SLOTS-1:0][ADDR_W-1:0] addrs;
    logic [SLOTS-1:0]             addr_ok;
    logic [IW-1:0]                ld_head, ld_tail, ld_cnt;
    logic [SLOTS-1:0]             occ;
    logic [IW-1:0]                cm_take, sq_take;
    logic                         do_alloc;

    // ---------------- store tracker state ----------------
    logic [SIW-1:0] st_head, st_tail, st_cnt;
    logic           st_full;

    // ---------------- violator state ----------------
    logic              viol_q;
    logic [IW-1:0]     viol_idx_q;
    logic [SEQ_W-1:0]  viol_seq_q;
    logic [CNT_W-1:0]  viol_cnt;
    logic              blk_q;
    logic [SEQ_W-1:0]  blk_seq_q;
    logic              scan_hit;
    logic [IW-1:0]     scan_pick;

    assign ld_full  = (IW'(ring_step(32'(ld_tail), 1, SLOTS)) == ld_head);
    assign do_alloc = alloc_ld && !ld_full && !squash_valid;
    assign st_full  = (SIW'(ring_step(32'(st_tail), 1, SSLOTS)) == st_head);

    generate
        for (genvar i = 0; i < SLOTS; i++) begin : g_occ
            assign occ[i] = ring_dist(32'(ld_head), i, SLOTS) < 32'(ld_cnt);
        end
    endgenerate

    lq_sweep #(.SLOTS(SLOTS), .IW(IW), .SEQ_W(SEQ_W), .DIR(SWEEP_FROM_HEAD)) u_commit (
        .seqs(seqs), .origin(ld_head), .cnt(ld_cnt), .bound(commit_seq), .take(cm_take)
    );

    lq_sweep #(.SLOTS(SLOTS), .IW(IW), .SEQ_W(SEQ_W), .DIR(SWEEP_FROM_TAIL)) u_squash (
        .seqs(seqs), .origin(ld_tail), .cnt(ld_cnt), .bound(squash_seq), .take(sq_take)
    );

    lq_scan #(.SLOTS(SLOTS), .IW(IW), .ADDR_W(ADDR_W)) u_scan (
        .addrs(addrs), .live(occ & addr_ok), .start(st_exec_lqidx), .tail(ld_tail),
        .st_addr(st_exec_addr), .hit(scan_hit), .pick(scan_pick)
    );

    assign st_fault = st_exec && !viol_q && scan_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            seqs    <= '0;
            addrs   <= '0;
            addr_ok <= '0;
            ld_head <= '0;
            ld_tail <= '0;
            ld_cnt  <= '0;
        end else begin
            if (ld_addr_wr) begin
                addrs[ld_addr_idx]   <= ld_addr;
                addr_ok[ld_addr_idx] <= 1'b1;
            end
            if (squash_valid) begin
                ld_tail <= IW'(ring_step(32'(ld_tail), SLOTS - 32'(sq_take), SLOTS));
                ld_cnt  <= ld_cnt - sq_take;
            end else begin
                if (commit_valid)
                    ld_head <= IW'(ring_step(32'(ld_head), 32'(cm_take), SLOTS));
                if (do_alloc) begin
                    seqs[ld_tail]    <= alloc_ld_seq;
                    addr_ok[ld_tail] <= 1'b0;
                    ld_tail <= IW'(ring_step(32'(ld_tail), 1, SLOTS));
                end
                ld_cnt <= ld_cnt - (commit_valid ? cm_take : '0) + IW'(do_alloc);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_head <= '0;
            st_tail <= '0;
            st_cnt  <= '0;
        end else begin
            if (st_alloc && !st_full)
                st_tail <= SIW'(ring_step(32'(st_tail), 1, SSLOTS));
            if (st_free && st_cnt != '0)
                st_head <= SIW'(ring_step(32'(st_head), 1, SSLOTS));
            st_cnt <= st_cnt + SIW'(st_alloc && !st_full) - SIW'(st_free && st_cnt != '0);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            viol_q     <= 1'b0;
            viol_idx_q <= '0;
            viol_seq_q <= '0;
            viol_cnt   <= '0;
            blk_q      <= 1'b0;
            blk_seq_q  <= '0;
        end else begin
            if (viol_q && viol_rd) begin
                viol_q <= 1'b0;
            end else if (st_fault) begin
                viol_q     <= 1'b1;
                viol_idx_q <= scan_pick;
                viol_seq_q <= seqs[scan_pick];
                viol_cnt   <= viol_cnt + CNT_W'(1);
            end
            if (blk_set) begin
                blk_q     <= 1'b1;
                blk_seq_q <= blk_seq;
            end else if (squash_valid && blk_q && (squash_seq < blk_seq_q)) begin
                blk_q <= 1'b0;
            end
        end
    end

    always_comb begin
        int unsigned lf, sf;
        lf = LQ_DEPTH - 32'(ld_cnt);
        sf = SQ_DEPTH - 32'(st_cnt);
        free_entries = FW'((lf < sf) ? lf : sf);
    end

    assign alloc_ld_idx   = ld_tail;
    assign alloc_ld_sqtag = (st_cnt == '0) ? '1 : {1'b0, st_tail};
    assign alloc_st_lqidx = ld_tail;
    assign viol_valid     = viol_q;
    assign viol_idx       = viol_idx_q;
    assign viol_seq       = viol_seq_q;
    assign viol_count     = viol_cnt;
    assign ld_blocked     = blk_q;
    assign ld_count       = ld_cnt;

    // ---------------- assertions ----------------
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        32'(ld_cnt) <= LQ_DEPTH); // R1
    AST_NO_ALLOC_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
        (ld_full && alloc_ld && !commit_valid && !squash_valid) |=> ld_cnt == $past(ld_cnt)); // R1
    AST_FAULT_LATCHES: assert property (@(posedge clk) disable iff (rst)
        st_fault |=> viol_q); // R5
    AST_FAULT_COUNTS: assert property (@(posedge clk) disable iff (rst)
        st_fault |=> viol_cnt == CNT_W'($past(viol_cnt) + CNT_W'(1))); // R5
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (viol_q && !viol_rd) |=> (viol_q && $stable(viol_idx_q) && $stable(viol_cnt))); // R6
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (viol_q && viol_rd) |=> !viol_q); // R6
    AST_SQUASH_NO_GROW: assert property (@(posedge clk) disable iff (rst)
        squash_valid |=> ld_cnt <= $past(ld_cnt)); // R9
    AST_STORE_BOUND: assert property (@(posedge clk) disable iff (rst)
        32'(st_cnt) <= SQ_DEPTH); // R12
endmodule

// File: tb/sim_load_order_queue.sv
module sim_load_order_queue;
    localparam int PERIOD = 10;
    localparam int LQD = 3, SQD = 2, AW = 12, SW = 8, CW = 8;
    localparam int IW = 2, SIW = 2, FW = 2;

    logic clk = 0, rst = 1;
    logic alloc_ld = 0, ld_addr_wr = 0, st_alloc = 0, st_free = 0, st_exec = 0;
    logic viol_rd = 0, commit_valid = 0, squash_valid = 0, blk_set = 0;
    logic [SW-1:0] alloc_ld_seq = '0, commit_seq = '0, squash_seq = '0, blk_seq = '0;
    logic [IW-1:0] ld_addr_idx = '0, st_exec_lqidx = '0;
    logic [AW-1:0] ld_addr = '0, st_exec_addr = '0;
    logic [IW-1:0] alloc_ld_idx, alloc_st_lqidx, viol_idx, ld_count;
    logic [SIW:0]  alloc_ld_sqtag;
    logic st_fault, viol_valid, ld_blocked, ld_full;
    logic [SW-1:0] viol_seq;
    logic [CW-1:0] viol_count;
    logic [FW-1:0] free_entries;

    int checks = 0, errors = 0;
    bit done = 0;

    always #(PERIOD/2) clk = ~clk;

    load_order_queue #(.LQ_DEPTH(LQD), .SQ_DEPTH(SQD), .ADDR_W(AW), .SEQ_W(SW), .CNT_W(CW)) u0 (
        .clk, .rst, .alloc_ld, .alloc_ld_seq, .alloc_ld_idx, .alloc_ld_sqtag,
        .ld_addr_wr, .ld_addr_idx, .ld_addr, .st_alloc, .st_free, .alloc_st_lqidx,
        .st_exec, .st_exec_addr, .st_exec_lqidx, .st_fault, .viol_valid, .viol_idx,
        .viol_seq, .viol_rd, .viol_count, .commit_valid, .commit_seq, .squash_valid,
        .squash_seq, .blk_set, .blk_seq, .ld_blocked, .ld_count, .ld_full, .free_entries
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic do_reset();
        rst = 1; tick(); tick(); rst = 0;
    endtask

    task automatic ld(input int seq);
        alloc_ld = 1; alloc_ld_seq = SW'(seq); tick(); alloc_ld = 0;
    endtask

    task automatic set_addr(input int idx, input int a);
        ld_addr_wr = 1; ld_addr_idx = IW'(idx); ld_addr = AW'(a); tick(); ld_addr_wr = 0;
    endtask

    // drives a store execute; checks the fault flag inside the execute cycle
    task automatic exec_st(input int idx, input int a, input int exp_fault, input string req);
        st_exec = 1; st_exec_lqidx = IW'(idx); st_exec_addr = AW'(a);
        #2; check(req, int'(st_fault), exp_fault);
        tick(); st_exec = 0;
    endtask

    task automatic rd_viol();
        viol_rd = 1; tick(); viol_rd = 0;
    endtask

    task automatic commit(input int s);
        commit_valid = 1; commit_seq = SW'(s); tick(); commit_valid = 0;
    endtask

    task automatic squash(input int s);
        squash_valid = 1; squash_seq = SW'(s); tick(); squash_valid = 0;
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // reset state
        check("R1 reset count", int'(ld_count), 0);
        check("R2 reset sqtag empty", int'(alloc_ld_sqtag), 7);
        check("R2 reset ld idx", int'(alloc_ld_idx), 0);
        check("R6 reset viol", int'(viol_valid), 0);
        check("R11 reset free", int'(free_entries), 2);

        // R1: fill and overflow
        ld(10); ld(11); ld(12);
        check("R1 full", int'(ld_full), 1);
        check("R1 count full", int'(ld_count), 3);
        ld(13);
        check("R1 alloc ignored count", int'(ld_count), 3);
        check("R1 alloc ignored tail", int'(alloc_ld_idx), 3);
        check("R11 free with full lq", int'(free_entries), 0);

        // R8 commit
        commit(9);
        check("R8 commit none", int'(ld_count), 3);
        commit(11);
        check("R8 commit two", int'(ld_count), 1);
        check("R1 not full", int'(ld_full), 0);
        check("R11 free lq-limited", int'(free_entries), 2);

        // R2 / R12 store tracker snapshots
        do_reset();
        ld(1);
        check("R2 st snapshot lq tail", int'(alloc_st_lqidx), 1);
        st_alloc = 1; tick(); st_alloc = 0;
        check("R2 ld sqtag after store", int'(alloc_ld_sqtag), 1);
        check("R11 free sq-limited", int'(free_entries), 1);
        st_alloc = 1; tick(); tick(); st_alloc = 0;
        check("R12 store full ignores", int'(alloc_ld_sqtag), 2);
        check("R11 free zero", int'(free_entries), 0);
        st_free = 1; tick(); tick(); tick(); st_free = 0;
        check("R12 store empty again", int'(alloc_ld_sqtag), 7);
        check("R12 free restored", int'(free_entries), 2);

        // R3 R4 R5 R6: exhaustive start x match pattern
        for (int s = 0; s < 3; s++) begin
            for (int m = 0; m < 8; m++) begin
                int first;
                do_reset();
                ld(1); ld(2); ld(3);
                for (int j = 0; j < 3; j++)
                    set_addr(j, m[j] ? (12'h3C0 | j) : 12'h4A5);
                first = -1;
                for (int j = 2; j >= s; j--)
                    if (m[j]) first = j;
                exec_st(s, 12'h3A5, first >= 0, "R3 fault window");
                check("R5 viol valid", int'(viol_valid), first >= 0);
                if (first >= 0) begin
                    check("R5 oldest idx", int'(viol_idx), first);
                    check("R5 viol seq", int'(viol_seq), first + 1);
                    check("R5 count", int'(viol_count), 1);
                    rd_viol();
                    check("R6 read clears", int'(viol_valid), 0);
                end else begin
                    check("R4 no count", int'(viol_count), 0);
                end
            end
        end

        // R6 sticky
        do_reset();
        ld(1); ld(2);
        set_addr(0, 12'h155); set_addr(1, 12'h1AA);
        exec_st(0, 12'h100, 1, "R5 first fault");
        exec_st(1, 12'h100, 0, "R6 sticky no fault");
        check("R6 idx held", int'(viol_idx), 0);
        check("R6 count held", int'(viol_count), 1);

        // R7 unaddressed load
        do_reset();
        ld(1); ld(2);
        set_addr(0, 12'h800);
        exec_st(0, 12'h0FF, 0, "R7 no address no match");

        // R3 wraparound and stale slots
        do_reset();
        ld(1); ld(2); ld(3);
        set_addr(1, 12'h7F0);
        commit(2);                      // head=2, one load (seq 3)
        ld(4); ld(5);                   // slots 3,0; tail=1
        check("R3 tail wrapped", int'(alloc_ld_idx), 1);
        set_addr(2, 12'h200); set_addr(3, 12'h300); set_addr(0, 12'h7AA);
        exec_st(3, 12'h700, 1, "R3 wrap window");
        check("R3 wrap idx", int'(viol_idx), 0);
        check("R3 wrap seq", int'(viol_seq), 5);
        rd_viol();
        exec_st(1, 12'h700, 0, "R3 empty window stale slot");
        exec_st(2, 12'h201, 1, "R3 from older start");
        check("R3 older idx", int'(viol_idx), 2);

        // R9 squash and priority over alloc
        do_reset();
        ld(1); ld(2); ld(3);
        squash(1);
        check("R9 squash count", int'(ld_count), 1);
        check("R9 squash tail", int'(alloc_ld_idx), 1);
        squash_valid = 1; squash_seq = 0; alloc_ld = 1; alloc_ld_seq = 9;
        tick(); squash_valid = 0; alloc_ld = 0;
        check("R9 squash beats alloc", int'(ld_count), 0);

        // R10 blocked flag
        blk_set = 1; blk_seq = 5; tick(); blk_set = 0;
        check("R10 set", int'(ld_blocked), 1);
        squash(6);
        check("R10 kept", int'(ld_blocked), 1);
        squash(4);
        check("R10 cleared", int'(ld_blocked), 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule